// File: doc/BRIEF.md
# Single-Wire Bus Device ID Enumerator

This block walks the binary tree of 64-bit device IDs on a single-wire bus and returns one new ID per search pass. It does not drive the bus. It issues commands to a separate bus master: a bus reset with presence detection, a byte write, and single-bit time slots. The master reports each completed command with a done strobe and the bit it sampled.

Between passes the block keeps three items: the previously found ID, the position of the last unresolved branch, and a finished flag. A host pulses start once per pass. Each pass ends in one of two ways: a one-cycle valid pulse with the new ID, or a one-cycle no-device pulse. The finished flag rises once the tree holds no further branch to explore. A restart pulse clears the stored state so that the enumeration can begin again.

Top module: `sw_rom_search`

## Requirements
- R1: A start pulse while the block is idle and finished is low begins a pass whose first command is a bus reset (cmd_kind_o = 0). Start is ignored while a pass is running and while finished is high.
- R2: If the reset response carries rsp_bit_i = 0 (no presence), the block pulses no_dev_o in the cycle after that response, sets finished_o, issues no further command and gives no ID.
- R3: After a reset response with presence, the next command is a byte write (cmd_kind_o = 1) with cmd_data_o = 0xF0.
- R4: For each of the 64 bit positions, the block issues two bit slots with cmd_data_o = 0x01 (cmd_kind_o = 2) to read the bit and its complement. It then issues one bit slot whose cmd_data_o[0] carries the chosen direction and whose upper bits are 0. The value sampled during that write slot is discarded, so a pass has exactly 2 + 3*64 commands.
- R5: A read pair (0,1) selects direction 0 and a pair (1,0) selects direction 1.
- R6: A read pair (1,1) aborts the pass. The block pulses no_dev_o in the cycle after the second read response, sets finished_o and issues no further command.
- R7: A read pair (0,0) at a position below the stored last discrepancy repeats the previous ID's bit at that position. Otherwise it selects 1 exactly at the last-discrepancy position and 0 elsewhere. Each 0 choice taken at a (0,0) pair records that position as the pass's last-zero position, which is cleared when the pass starts.
- R8: Chosen directions form the ID with the first transferred bit as bit 0. id_valid_o pulses for one cycle, in the cycle after the response to the 64th write slot, and id_o holds the ID from then on.
- R9: At the end of a full pass, the last discrepancy takes the last-zero position, and finished_o is set exactly when that position is 0.
- R10: A restart pulse while idle clears the previous ID, the last discrepancy and finished_o.
- R11: cmd_valid_o is high for exactly one cycle per command, and the next command is not issued before rsp_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin one search pass |
| restart_i | input | 1 | Clear stored search state (idle only) |
| cmd_valid_o | output | 1 | One-cycle command strobe to the bus master |
| cmd_kind_o | output | 2 | 0 reset, 1 byte write, 2 bit slot |
| cmd_data_o | output | 8 | Byte to write, or bit to send in bit 0 |
| rsp_done_i | input | 1 | Master finished the current command |
| rsp_bit_i | input | 1 | Presence (reset) or sampled bus bit (bit slot) |
| id_o | output | ID_W | Most recently found ID |
| id_valid_o | output | 1 | One-cycle pulse: id_o holds a new ID |
| no_dev_o | output | 1 | One-cycle pulse: pass ended without an ID |
| finished_o | output | 1 | Enumeration complete |

## Verification
Every result is registered, so it is due exactly one clock after the master response that causes it. The ID pulse follows the 64th write-slot response. The no-device pulse follows either the reset response or the second read of an aborting position. A new command strobe follows any other response. The bench's bus model answers each command three cycles after it sees the strobe. It clears its done strobe on the next falling edge and checks the expected pulse at that same falling edge. The finished flag and the per-pass command count are sampled two falling edges after the scoreboard has seen the result.

// File: rtl/sw_search_pkg.sv
package sw_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RST,
        S_CMD,
        S_RD1,
        S_RD2,
        S_WR
    } state_t;

    localparam logic [1:0] KIND_RESET = 2'd0;
    localparam logic [1:0] KIND_BYTE  = 2'd1;
    localparam logic [1:0] KIND_BIT   = 2'd2;

    localparam logic [7:0] SEARCH_CMD = 8'hF0;

endpackage

// File: rtl/sw_branch_pick.sv
module sw_branch_pick #(
    parameter int IDX_W = 6
) (
    input  logic             rd_true,
    input  logic             rd_comp,
    input  logic [IDX_W-1:0] pos,
    input  logic [IDX_W-1:0] last_disc,
    input  logic             prev_bit,
    output logic             dir,
    output logic             zero_pick,
    output logic             silent
);

    logic split;

    always_comb begin
        split  = !rd_true && !rd_comp;
        silent = rd_true && rd_comp;
        if (split) begin
            if (pos < last_disc) dir = prev_bit;
            else                 dir = (pos == last_disc);
        end else begin
            dir = rd_true;
        end
        zero_pick = split && !dir;
    end

endmodule

// File: rtl/sw_cmd_fmt.sv
module sw_cmd_fmt
    import sw_search_pkg::*;
(
    input  state_t      state,
    input  logic        dir,
    output logic [1:0]  kind,
    output logic [7:0]  data
);

    always_comb begin
        kind = KIND_RESET;
        data = 8'h00;
        case (state)
            S_RST: kind = KIND_RESET;
            S_CMD: begin
                kind = KIND_BYTE;
                data = SEARCH_CMD;
            end
            S_RD1, S_RD2: begin
                kind = KIND_BIT;
                data = 8'h01;
            end
            S_WR: begin
                kind = KIND_BIT;
                data = {7'b0, dir};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sw_rom_search.sv
module sw_rom_search
    import sw_search_pkg::*;
#(
    parameter int ID_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            restart_i,
    output logic            cmd_valid_o,
    output logic [1:0]      cmd_kind_o,
    output logic [7:0]      cmd_data_o,
    input  logic            rsp_done_i,
    input  logic            rsp_bit_i,
    output logic [ID_W-1:0] id_o,
    output logic            id_valid_o,
    output logic            no_dev_o,
    output logic            finished_o
);

    localparam int             IDX_W    = $clog2(ID_W);
    localparam logic [IDX_W-1:0] LAST_POS = IDX_W'(ID_W - 1);

    typedef struct packed {
        state_t           state;
        logic             waiting;
        logic [IDX_W-1:0] pos;
        logic             rd_true;
        logic             dir;
        logic [ID_W-1:0]  acc;
        logic [ID_W-1:0]  prev_id;
        logic [IDX_W-1:0] last_disc;
        logic [IDX_W-1:0] last_zero;
        logic             finished;
        logic             id_valid;
        logic             no_dev;
    } regs_t;

    regs_t q, d;

    logic pick_dir, pick_zero, pick_silent, done;

    sw_branch_pick #(.IDX_W(IDX_W)) i_pick (
        .rd_true   (q.rd_true),
        .rd_comp   (rsp_bit_i),
        .pos       (q.pos),
        .last_disc (q.last_disc),
        .prev_bit  (q.prev_id[q.pos]),
        .dir       (pick_dir),
        .zero_pick (pick_zero),
        .silent    (pick_silent)
    );

    sw_cmd_fmt i_fmt (
        .state (q.state),
        .dir   (q.dir),
        .kind  (cmd_kind_o),
        .data  (cmd_data_o)
    );

    always_comb begin
        d           = q;
        d.id_valid  = 1'b0;
        d.no_dev    = 1'b0;
        cmd_valid_o = (q.state != S_IDLE) && !q.waiting;
        done        = q.waiting && rsp_done_i;
        if (cmd_valid_o) d.waiting = 1'b1;
        if (done)        d.waiting = 1'b0;

        case (q.state)
            S_IDLE: begin
                if (start_i && !q.finished) begin
                    d.state     = S_RST;
                    d.last_zero = '0;
                end else if (restart_i) begin
                    d.prev_id   = '0;
                    d.last_disc = '0;
                    d.finished  = 1'b0;
                end
            end
            S_RST: if (done) begin
                if (rsp_bit_i) begin
                    d.state = S_CMD;
                end else begin
                    d.state    = S_IDLE;
                    d.finished = 1'b1;
                    d.no_dev   = 1'b1;
                end
            end
            S_CMD: if (done) begin
                d.state = S_RD1;
                d.pos   = '0;
            end
            S_RD1: if (done) begin
                d.rd_true = rsp_bit_i;
                d.state   = S_RD2;
            end
            S_RD2: if (done) begin
                if (pick_silent) begin
                    d.state    = S_IDLE;
                    d.finished = 1'b1;
                    d.no_dev   = 1'b1;
                end else begin
                    d.dir   = pick_dir;
                    d.state = S_WR;
                    if (pick_zero) d.last_zero = q.pos;
                end
            end
            S_WR: if (done) begin
                d.acc = {q.dir, q.acc[ID_W-1:1]};
                if (q.pos == LAST_POS) begin
                    d.state     = S_IDLE;
                    d.prev_id   = {q.dir, q.acc[ID_W-1:1]};
                    d.last_disc = q.last_zero;
                    d.finished  = (q.last_zero == '0);
                    d.id_valid  = 1'b1;
                end else begin
                    d.pos   = q.pos + 1'b1;
                    d.state = S_RD1;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign id_o       = q.prev_id;
    assign id_valid_o = q.id_valid;
    assign no_dev_o   = q.no_dev;
    assign finished_o = q.finished;

    // R11: each command strobe lasts a single cycle
    p_cmd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R8: the ID strobe is a single-cycle pulse
    p_id_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid_o |=> !id_valid_o);

    // R2: a pass never yields both an ID and a no-device result
    p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(id_valid_o && no_dev_o));

    // R6: an empty result always leaves the search finished
    p_nodev_fin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        no_dev_o |-> finished_o);

    // R1: start is ignored once finished
    p_start_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_IDLE && finished_o && start_i) |=> (q.state == S_IDLE));

    // R4: a write slot only follows the second read slot
    p_wr_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_WR && $past(q.state) != S_WR) |-> $past(q.state) == S_RD2);

endmodule

// File: tb/test_sw_rom_search.sv
`timescale 1ns/1ps
module test_sw_rom_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        restart_i = 1'b0;
    logic        cmd_valid_o;
    logic [1:0]  cmd_kind_o;
    logic [7:0]  cmd_data_o;
    logic        rsp_done_i = 1'b0;
    logic        rsp_bit_i = 1'b0;
    logic [63:0] id_o;
    logic        id_valid_o;
    logic        no_dev_o;
    logic        finished_o;

    always #2.5 clk = ~clk;

    sw_rom_search #(.ID_W(64)) i_sw_rom_search (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .restart_i   (restart_i),
        .cmd_valid_o (cmd_valid_o),
        .cmd_kind_o  (cmd_kind_o),
        .cmd_data_o  (cmd_data_o),
        .rsp_done_i  (rsp_done_i),
        .rsp_bit_i   (rsp_bit_i),
        .id_o        (id_o),
        .id_valid_o  (id_valid_o),
        .no_dev_o    (no_dev_o),
        .finished_o  (finished_o)
    );

    int checks = 0;
    int errors = 0;
    int cmd_cnt = 0;
    int res_cnt = 0;
    bit ended = 1'b0;

    typedef struct { bit nodev; logic [63:0] id; } exp_t;
    exp_t sb[$];

    logic [63:0] dev [4];
    int          ndev = 0;
    int          abort_pos = -1;
    logic [63:0] exp_cur = '0;

    localparam logic [63:0] BASE = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] D0 = BASE;
    localparam logic [63:0] D1 = BASE ^ 64'h2;
    localparam logic [63:0] D2 = BASE ^ 64'h8;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bus master and device model
    initial begin : master
        bit act [4];
        int p = 0;
        int ph = 0;
        logic [1:0] kind;
        logic [7:0] data;
        logic rbit;
        bit last;
        bit abort_now;
        @(negedge clk);
        forever begin
            if (cmd_valid_o) begin
                kind = cmd_kind_o;
                data = cmd_data_o;
                cmd_cnt++;
                last = 1'b0;
                abort_now = 1'b0;
                rbit = 1'b0;
                @(negedge clk);
                chk(!cmd_valid_o, "R11 strobe width", 64'(cmd_valid_o), 64'h0);
                repeat (2) @(negedge clk);
                case (kind)
                    2'd0: begin
                        for (int i = 0; i < 4; i++) act[i] = (i < ndev);
                        p = 0; ph = 0;
                        rbit = (ndev > 0);
                    end
                    2'd1: chk(data == 8'hF0, "R3 search byte", 64'(data), 64'hF0);
                    2'd2: begin
                        if (ph == 0) begin
                            chk(data == 8'h01, "R4 read slot data", 64'(data), 64'h01);
                            rbit = 1'b1;
                            for (int i = 0; i < 4; i++) if (act[i] && !dev[i][p]) rbit = 1'b0;
                            if (p == abort_pos) rbit = 1'b1;
                            ph = 1;
                        end else if (ph == 1) begin
                            chk(data == 8'h01, "R4 read slot data", 64'(data), 64'h01);
                            rbit = 1'b1;
                            for (int i = 0; i < 4; i++) if (act[i] && dev[i][p]) rbit = 1'b0;
                            if (p == abort_pos) begin rbit = 1'b1; abort_now = 1'b1; end
                            ph = 2;
                        end else begin
                            chk(data == {7'b0, exp_cur[p]}, "R7 R5 direction bit", 64'(data), 64'(exp_cur[p]));
                            for (int i = 0; i < 4; i++) if (dev[i][p] != data[0]) act[i] = 1'b0;
                            rbit = ~data[0];
                            p++; ph = 0;
                            last = (p == 64);
                        end
                    end
                    default: chk(1'b0, "R4 command kind", 64'(kind), 64'h2);
                endcase
                rsp_bit_i = rbit;
                rsp_done_i = 1'b1;
                @(negedge clk);
                rsp_done_i = 1'b0;
                if (kind == 2'd0 && !rbit)
                    chk(no_dev_o, "R2 no-device pulse timing", 64'(no_dev_o), 64'h1);
                if (abort_now)
                    chk(no_dev_o, "R6 abort pulse timing", 64'(no_dev_o), 64'h1);
                if (last)
                    chk(id_valid_o, "R8 id pulse timing", 64'(id_valid_o), 64'h1);
            end else begin
                @(negedge clk);
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (id_valid_o || no_dev_o)) begin
            res_cnt++;
            if (sb.size() == 0) begin
                chk(1'b0, "R1 unexpected result", id_o, 64'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(no_dev_o == e.nodev, "R2 R6 result kind", 64'(no_dev_o), 64'(e.nodev));
                if (!e.nodev) chk(id_o == e.id, "R8 found ID", id_o, e.id);
            end
        end
    end

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
    endtask

    task automatic do_pass(input bit nodev, input logic [63:0] id, input bit exp_fin,
                           input int exp_cmds, input bit extra_start);
        int c0, r0;
        exp_t e;
        e.nodev = nodev; e.id = id;
        sb.push_back(e);
        exp_cur = id;
        c0 = cmd_cnt; r0 = res_cnt;
        pulse(start_i);
        if (extra_start) begin
            repeat (60) @(negedge clk);
            pulse(start_i);   // R1: ignored while running
        end
        wait (res_cnt == r0 + 1);
        repeat (2) @(negedge clk);
        chk(finished_o == exp_fin, "R9 finished flag", 64'(finished_o), 64'(exp_fin));
        chk(cmd_cnt - c0 == exp_cmds, "R4 commands per pass", 64'(cmd_cnt - c0), 64'(exp_cmds));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        int c0, r0;
        dev[0] = D0; dev[1] = D1; dev[2] = D2; dev[3] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!finished_o && !id_valid_o && !no_dev_o && !cmd_valid_o, "R1 reset state",
            {60'b0, finished_o, id_valid_o, no_dev_o, cmd_valid_o}, 64'h0);

        // R2: empty bus
        ndev = 0;
        do_pass(1'b1, '0, 1'b1, 1, 1'b0);

        // R1: start ignored when finished
        c0 = cmd_cnt; r0 = res_cnt;
        pulse(start_i);
        repeat (20) @(negedge clk);
        chk(cmd_cnt == c0 && res_cnt == r0, "R1 start ignored after finish", 64'(cmd_cnt - c0), 64'h0);

        // R10: restart clears stored state
        pulse(restart_i);
        @(negedge clk);
        chk(!finished_o && id_o == '0, "R10 restart clears state", {63'b0, finished_o}, 64'h0);

        // R5 R7 R9: three devices, order D0, D2, D1
        ndev = 3;
        do_pass(1'b0, D0, 1'b0, 194, 1'b0);
        do_pass(1'b0, D2, 1'b0, 194, 1'b1);
        do_pass(1'b0, D1, 1'b1, 194, 1'b0);
        chk(id_o == D1, "R8 id held after pulse", id_o, D1);

        // R6: all-ones read pair aborts
        pulse(restart_i);
        ndev = 1; abort_pos = 5;
        do_pass(1'b1, D0, 1'b1, 19, 1'b0);

        // R9: single device finishes in one pass
        pulse(restart_i);
        abort_pos = -1;
        dev[0] = D1;
        do_pass(1'b0, D1, 1'b1, 194, 1'b0);

        repeat (5) @(negedge clk);
        chk(sb.size() == 0, "R8 all results seen", 64'(sb.size()), 64'h0);
        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule